// File: doc/BRIEF.md
# Thermal Event Output Controller

This block turns a stream of signed temperature samples into the level of one alarm pin. It tracks three conditions: the reading has risen above an upper limit, fallen below a lower limit, or risen above a critical limit. Each condition is set by a strict crossing. It is released only after the reading has come back across the limit by a selectable hysteresis margin. Temperatures and limits are two's complement with 0.125 °C per LSB.

Three behaviours share the pin. In comparator mode it follows the conditions, like a thermostat. In interrupt mode a window crossing is latched until the host clears it. In critical-only mode it reflects only the critical condition. The pin is driven as an open-drain enable, with selectable active level and a master enable. A status bit reports the event for readback. Samples arrive only with a strobe, a few times per second, from an external converter.

Top module: `thermal_event_ctrl`

## Requirements
- R1: After reset, and before any sample strobe, the event is inactive: `event_status_o` is 0 and `event_pull_o` equals `cfg_enable_i & cfg_active_high_i`.
- R2: A strobed sample strictly greater than `upper_lim_i` sets the over-upper condition; in comparator mode with the block enabled, `event_status_o` is 1 one clock after the strobe.
- R3: A strobed sample strictly less than `lower_lim_i` sets the under-lower condition, which is reported in the same way as R2.
- R4: Hysteresis H is 0, 12, 24 or 48 LSB for `cfg_hyst_sel_i` = 0, 1, 2 or 3. A set over-type condition clears on a sample <= limit − H. A set under-lower condition clears on a sample >= lower + H. Samples in between leave the condition unchanged.
- R5: A strobed sample strictly greater than `crit_lim_i` sets the critical condition, which clears on a sample <= crit − H. It asserts the event in every mode, and `int_clear_i` has no effect on it.
- R6: With `cfg_crit_only_i` = 1, the over-upper and under-lower conditions neither assert the event nor set the interrupt latch.
- R7: In interrupt mode (`cfg_int_mode_i` = 1), a strobed sample that turns the window condition (over-upper OR under-lower) from false to true sets a latch. The latch holds through later samples until a cycle with `int_clear_i` = 1. A set and a clear in the same cycle leave the latch set. The latch is held at 0 while interrupt mode is off. The event is the latch OR the critical condition.
- R8: With `cfg_active_high_i` = 0, `event_pull_o` = 1 exactly while the event is active. With `cfg_active_high_i` = 1, `event_pull_o` = 1 exactly while it is inactive.
- R9: With `cfg_enable_i` = 0, `event_pull_o` and `event_status_o` are both 0, whatever the polarity.
- R10: Changes of `temp_i` without `temp_vld_i` do not change any condition.
- R11: All comparisons are signed. A sample equal to a limit does not set that limit's condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_i | input | TEMP_W | Signed temperature sample, 0.125 °C/LSB |
| temp_vld_i | input | 1 | Sample strobe, one cycle |
| upper_lim_i | input | TEMP_W | Signed upper limit |
| lower_lim_i | input | TEMP_W | Signed lower limit |
| crit_lim_i | input | TEMP_W | Signed critical limit |
| cfg_int_mode_i | input | 1 | 1 = interrupt mode, 0 = comparator mode |
| cfg_active_high_i | input | 1 | 1 = pin high when active |
| cfg_enable_i | input | 1 | Output enable |
| cfg_crit_only_i | input | 1 | Event only from the critical condition |
| cfg_hyst_sel_i | input | 2 | Hysteresis select |
| int_clear_i | input | 1 | Clears the interrupt latch |
| event_pull_o | output | 1 | 1 = pull the open-drain pin low |
| event_status_o | output | 1 | Event active and enabled |

## Verification
Each condition and the interrupt latch are registered on the edge that captures a strobe. The two outputs are combinational from those registers and from the configuration. A sample therefore shows up one edge after the strobe, and a configuration change shows up at once. The bench drives on the falling edge and checks on the next falling edge, one clock later. By then the capturing edge has passed and nothing else has moved. Its model is advanced at the rising edge from the same input values, so every comparison lines up with that edge.

// File: rtl/thermal_event_pkg.sv
// Package: shared condition type and hysteresis width function
// for the thermal event controller. Assumes hysteresis steps are
// 0, 1, 2 and 4 times a base step.
package thermal_event_pkg;

    // One flag per tracked limit condition.
    typedef struct packed {
        logic crit;
        logic lower;
        logic upper;
    } cond_t;

    localparam int NUM_LIMITS = 3;
    localparam int IDX_UPPER  = 0;
    localparam int IDX_LOWER  = 1;
    localparam int IDX_CRIT   = 2;

    // Hysteresis width in LSB for a 2-bit select and a base step.
    function automatic int hyst_width(input logic [1:0] sel, input int step);
        int w;
        case (sel)
            2'd0:    w = 0;
            2'd1:    w = step;
            2'd2:    w = step * 2;
            default: w = step * 4;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/te_limit_track.sv
// Module: tracks one limit condition with hysteresis.
// Sets on a strict crossing, clears once the sample is back past
// the limit by the hysteresis width, otherwise holds. Updates only
// on a sample strobe. ABOVE selects over-type (1) or under-type (0).
// Assumes hyst fits HW bits; arithmetic is widened by two bits.
module te_limit_track #(
    parameter int TEMP_W = 11,
    parameter int HW     = 6,
    parameter bit ABOVE  = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_vld,
    input  logic signed [TEMP_W-1:0] sample,
    input  logic signed [TEMP_W-1:0] limit,
    input  logic        [HW-1:0]     hyst,
    output logic                     flag_o,
    output logic                     flag_nxt_o
);

    localparam int CW = (TEMP_W > HW ? TEMP_W : HW) + 2;

    logic signed [CW-1:0] s_w, l_w, h_w, rel_pt;
    logic                 crossed, released;

    // Widen operands and compute the release point.
    always_comb begin
        s_w = CW'(sample);
        l_w = CW'(limit);
        h_w = $signed({{(CW-HW){1'b0}}, hyst});
        if (ABOVE) begin
            rel_pt   = l_w - h_w;
            crossed  = s_w > l_w;
            released = s_w <= rel_pt;
        end else begin
            rel_pt   = l_w + h_w;
            crossed  = s_w < l_w;
            released = s_w >= rel_pt;
        end
    end

    // Next flag value if the current sample were captured.
    always_comb begin
        if (crossed)       flag_nxt_o = 1'b1;
        else if (released) flag_nxt_o = 1'b0;
        else               flag_nxt_o = flag_o;
    end

    // Capture the condition on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_o <= 1'b0;
        else if (sample_vld) flag_o <= flag_nxt_o;
    end

endmodule

// File: rtl/te_event_mode.sv
// Module: merges the limit conditions into one event according to
// the mode. Holds the interrupt latch, which is set by a false-to-true
// window transition on a strobe and cleared by the host. The critical
// condition bypasses the latch. Assumes flags_nxt is the value the
// flags take on a strobe edge.
module te_event_mode
    import thermal_event_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sample_vld,
    input  cond_t flags,
    input  cond_t flags_nxt,
    input  logic  int_mode,
    input  logic  crit_only,
    input  logic  int_clear,
    output logic  event_active_o
);

    logic win_now, win_nxt, win_rise, latch_q;

    // Window condition now and after a strobe, masked in critical-only mode.
    always_comb begin
        win_now  = ~crit_only & (flags.upper | flags.lower);
        win_nxt  = ~crit_only & (flags_nxt.upper | flags_nxt.lower);
        win_rise = sample_vld & win_nxt & ~win_now;
    end

    // Interrupt latch: set beats clear; held clear outside interrupt mode.
    always_ff @(posedge clk) begin
        if (!rst_n)         latch_q <= 1'b0;
        else if (!int_mode) latch_q <= 1'b0;
        else if (win_rise)  latch_q <= 1'b1;
        else if (int_clear) latch_q <= 1'b0;
    end

    // Event selection by mode.
    always_comb begin
        if (crit_only)     event_active_o = flags.crit;
        else if (int_mode) event_active_o = flags.crit | latch_q;
        else               event_active_o = flags.crit | win_now;
    end

endmodule

// File: rtl/te_pin_drive.sv
// Module: maps the event to the open-drain enable and the status bit.
// Assumes an external pull-up, so 1 on pull_o drives the pin low.
module te_pin_drive (
    input  logic enable,
    input  logic active_high,
    input  logic event_active,
    output logic pull_o,
    output logic status_o
);

    // Pin level and status, both released when disabled.
    always_comb begin
        status_o = enable & event_active;
        pull_o   = enable & (event_active ^ active_high);
    end

endmodule

// File: rtl/thermal_event_ctrl.sv
// Top: thermal event output controller. Tracks the over-upper,
// under-lower and critical conditions of strobed signed samples and
// drives a single alarm pin in comparator, interrupt or critical-only
// mode. Assumes limits are held stable between samples.
module thermal_event_ctrl
    import thermal_event_pkg::*;
#(
    parameter int TEMP_W    = 11,
    parameter int HYST_STEP = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] temp_i,
    input  logic                     temp_vld_i,
    input  logic signed [TEMP_W-1:0] upper_lim_i,
    input  logic signed [TEMP_W-1:0] lower_lim_i,
    input  logic signed [TEMP_W-1:0] crit_lim_i,
    input  logic                     cfg_int_mode_i,
    input  logic                     cfg_active_high_i,
    input  logic                     cfg_enable_i,
    input  logic                     cfg_crit_only_i,
    input  logic [1:0]               cfg_hyst_sel_i,
    input  logic                     int_clear_i,
    output logic                     event_pull_o,
    output logic                     event_status_o
);

    localparam int HW = $clog2(HYST_STEP * 4 + 1);

    logic        [HW-1:0]     hyst_amt;
    logic signed [TEMP_W-1:0] lim_arr [NUM_LIMITS];
    logic [NUM_LIMITS-1:0]    flag_vec, flag_nxt_vec;
    cond_t                    flags, flags_nxt;
    logic                     event_active;

    // Hysteresis width and limit vector.
    always_comb begin
        hyst_amt           = HW'(hyst_width(cfg_hyst_sel_i, HYST_STEP));
        lim_arr[IDX_UPPER] = upper_lim_i;
        lim_arr[IDX_LOWER] = lower_lim_i;
        lim_arr[IDX_CRIT]  = crit_lim_i;
    end

    for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_lim
        te_limit_track #(
            .TEMP_W (TEMP_W),
            .HW     (HW),
            .ABOVE  (g != IDX_LOWER)
        ) u_track (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_vld (temp_vld_i),
            .sample     (temp_i),
            .limit      (lim_arr[g]),
            .hyst       (hyst_amt),
            .flag_o     (flag_vec[g]),
            .flag_nxt_o (flag_nxt_vec[g])
        );
    end

    // Pack the per-limit flags into the condition structs.
    always_comb begin
        flags.upper     = flag_vec[IDX_UPPER];
        flags.lower     = flag_vec[IDX_LOWER];
        flags.crit      = flag_vec[IDX_CRIT];
        flags_nxt.upper = flag_nxt_vec[IDX_UPPER];
        flags_nxt.lower = flag_nxt_vec[IDX_LOWER];
        flags_nxt.crit  = flag_nxt_vec[IDX_CRIT];
    end

    te_event_mode u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_vld     (temp_vld_i),
        .flags          (flags),
        .flags_nxt      (flags_nxt),
        .int_mode       (cfg_int_mode_i),
        .crit_only      (cfg_crit_only_i),
        .int_clear      (int_clear_i),
        .event_active_o (event_active)
    );

    te_pin_drive u_pin (
        .enable       (cfg_enable_i),
        .active_high  (cfg_active_high_i),
        .event_active (event_active),
        .pull_o       (event_pull_o),
        .status_o     (event_status_o)
    );

endmodule

// File: rtl/thermal_event_ctrl_chk.sv
// Checker: port-level properties of the thermal event controller.
module thermal_event_ctrl_chk #(
    parameter int TEMP_W = 11
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic signed [TEMP_W-1:0] temp_i,
    input logic                     temp_vld_i,
    input logic signed [TEMP_W-1:0] lower_lim_i,
    input logic signed [TEMP_W-1:0] crit_lim_i,
    input logic                     cfg_int_mode_i,
    input logic                     cfg_active_high_i,
    input logic                     cfg_enable_i,
    input logic                     cfg_crit_only_i,
    input logic                     int_clear_i,
    input logic                     event_pull_o,
    input logic                     event_status_o
);

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable_i |-> (!event_pull_o && !event_status_o));

    assert_polarity_R8: assert property (@(posedge clk) disable iff (!rst_n)
        event_status_o |-> (event_pull_o == !cfg_active_high_i));

    assert_crit_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_vld_i && (temp_i > crit_lim_i)) |=> (event_status_o || !cfg_enable_i));

    assert_lower_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_vld_i && (temp_i < lower_lim_i) && !cfg_int_mode_i && !cfg_crit_only_i)
        |=> (event_status_o || !cfg_enable_i || cfg_int_mode_i || cfg_crit_only_i));

    assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (event_status_o && cfg_int_mode_i && !cfg_crit_only_i && !int_clear_i && !temp_vld_i)
        |=> (event_status_o || !cfg_enable_i || !cfg_int_mode_i || cfg_crit_only_i));

endmodule

bind thermal_event_ctrl thermal_event_ctrl_chk #(.TEMP_W(TEMP_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .temp_i            (temp_i),
    .temp_vld_i        (temp_vld_i),
    .lower_lim_i       (lower_lim_i),
    .crit_lim_i        (crit_lim_i),
    .cfg_int_mode_i    (cfg_int_mode_i),
    .cfg_active_high_i (cfg_active_high_i),
    .cfg_enable_i      (cfg_enable_i),
    .cfg_crit_only_i   (cfg_crit_only_i),
    .int_clear_i       (int_clear_i),
    .event_pull_o      (event_pull_o),
    .event_status_o    (event_status_o)
);

// File: tb/thermal_event_ctrl_bench.sv
`timescale 1ns/1ps
module thermal_event_ctrl_bench;

    localparam int TW = 11;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [TW-1:0] temp = '0, up_lim = 11'sd600, lo_lim = 11'sd80, cr_lim = 11'sd760;
    logic                 vld = 1'b0, int_mode = 1'b0, act_hi = 1'b0, en = 1'b1;
    logic                 crit_only = 1'b0, clr = 1'b0;
    logic [1:0]           hsel = 2'd0;
    logic                 pull, status;

    int checks = 0, failures = 0;
    bit m_up, m_lo, m_cr, m_latch;

    always #2 clk = ~clk;

    thermal_event_ctrl u_thermal_event_ctrl (
        .clk(clk), .rst_n(rst_n), .temp_i(temp), .temp_vld_i(vld),
        .upper_lim_i(up_lim), .lower_lim_i(lo_lim), .crit_lim_i(cr_lim),
        .cfg_int_mode_i(int_mode), .cfg_active_high_i(act_hi),
        .cfg_enable_i(en), .cfg_crit_only_i(crit_only),
        .cfg_hyst_sel_i(hsel), .int_clear_i(clr),
        .event_pull_o(pull), .event_status_o(status)
    );

    // Hysteresis width per R4.
    function automatic int hyst_of(input logic [1:0] s);
        case (s)
            2'd0: return 0;
            2'd1: return 12;
            2'd2: return 24;
            default: return 48;
        endcase
    endfunction

    function automatic bit exp_active();
        if (crit_only) return m_cr;
        if (int_mode)  return m_cr | m_latch;
        return m_cr | m_up | m_lo;
    endfunction

    function automatic bit exp_status();
        return en & exp_active();
    endfunction

    function automatic bit exp_pull();
        return en & (act_hi ? !exp_active() : exp_active());
    endfunction

    // Advance the model at a rising edge from the inputs then present.
    task automatic model_edge();
        int t, h;
        bit n_up, n_lo, n_cr, w_old, w_new;
        t = int'(temp); h = hyst_of(hsel);
        n_up = m_up; n_lo = m_lo; n_cr = m_cr;
        if (vld) begin
            if (t > int'(up_lim)) n_up = 1; else if (t <= int'(up_lim) - h) n_up = 0;
            if (t < int'(lo_lim)) n_lo = 1; else if (t >= int'(lo_lim) + h) n_lo = 0;
            if (t > int'(cr_lim)) n_cr = 1; else if (t <= int'(cr_lim) - h) n_cr = 0;
        end
        w_old = !crit_only && (m_up || m_lo);
        w_new = !crit_only && (n_up || n_lo);
        if (!int_mode) m_latch = 0;
        else if (vld && w_new && !w_old) m_latch = 1;
        else if (clr) m_latch = 0;
        m_up = n_up; m_lo = n_lo; m_cr = n_cr;
    endtask

    task automatic check_outs(input string tag);
        checks += 2;
        if (status !== exp_status()) begin
            failures++;
            $display("FAIL %s status actual=%0b expected=%0b", tag, status, exp_status());
        end
        if (pull !== exp_pull()) begin
            failures++;
            $display("FAIL %s pull actual=%0b expected=%0b", tag, pull, exp_pull());
        end
    endtask

    // One clock: inputs already set at a falling edge.
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_outs(tag);
        vld = 0; clr = 0;
    endtask

    task automatic sample(input int t, input string tag);
        temp = TW'(t); vld = 1; step(tag);
    endtask

    // Direct check of a named expectation on the status bit.
    task automatic expect_status(input bit e, input string tag);
        checks++;
        if (status !== e) begin
            failures++;
            $display("FAIL %s status actual=%0b expected=%0b", tag, status, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_up = 0; m_lo = 0; m_cr = 0; m_latch = 0;
        check_outs("R1");
        act_hi = 1; #1; check_outs("R1_act_high");
        act_hi = 0;
        // R11: equality does not trip; R2: one above does.
        sample(600, "R11"); expect_status(0, "R11_equal");
        sample(601, "R2");  expect_status(1, "R2_over");
        // R4: hysteresis 24.
        hsel = 2'd2;
        sample(577, "R4"); expect_status(1, "R4_hold");
        sample(576, "R4"); expect_status(0, "R4_release");
        // R10: no strobe, no change.
        temp = 11'sd900; step("R10"); expect_status(0, "R10_ignored");
        // R3 and its hysteresis.
        sample(79, "R3");  expect_status(1, "R3_under");
        sample(103, "R4"); expect_status(1, "R4_lower_hold");
        sample(104, "R4"); expect_status(0, "R4_lower_release");
        // R5: critical, clear has no effect.
        sample(761, "R5"); expect_status(1, "R5_crit");
        int_mode = 1; clr = 1; step("R5"); expect_status(1, "R5_clear_ignored");
        int_mode = 0;
        // R8 polarity.
        act_hi = 1; #1; check_outs("R8");
        act_hi = 0;
        // R9 disable.
        en = 0; #1; check_outs("R9"); expect_status(0, "R9_disabled");
        en = 1;
        // R6: critical-only hides window.
        crit_only = 1;
        sample(700, "R6"); expect_status(0, "R6_window_hidden");
        sample(50, "R6");  expect_status(0, "R6_lower_hidden");
        crit_only = 0;
        // R7 interrupt latch.
        int_mode = 1; step("R7");
        sample(300, "R7");
        sample(40, "R7");  expect_status(1, "R7_latched");
        sample(300, "R7"); expect_status(1, "R7_held");
        clr = 1; step("R7"); expect_status(0, "R7_cleared");
        sample(700, "R7"); clr = 1; temp = 11'sd300; vld = 1; step("R7_set_vs_clear");
        sample(40, "R7"); clr = 1; step("R7");
        // R11: negative limits.
        int_mode = 0; hsel = 2'd1; lo_lim = -11'sd80;
        sample(-81, "R11"); expect_status(1, "R11_negative");
        sample(-69, "R11"); expect_status(1, "R11_neg_hold");
        sample(-68, "R11"); expect_status(0, "R11_neg_release");
        // Random phase.
        for (int i = 0; i < 3000; i++) begin
            if (i % 150 == 0) begin
                lo_lim    = TW'($signed(int'($urandom_range(0, 400)) - 200));
                up_lim    = TW'(int'(lo_lim) + int'($urandom_range(20, 300)));
                cr_lim    = TW'(int'(up_lim) + int'($urandom_range(0, 200)));
                int_mode  = 1'($urandom_range(0, 1));
                crit_only = ($urandom_range(0, 3) == 0);
                act_hi    = 1'($urandom_range(0, 1));
                en        = ($urandom_range(0, 7) != 0);
                hsel      = 2'($urandom_range(0, 3));
            end
            temp = TW'(int'(lo_lim) - 80 + int'($urandom_range(0, 32'(int'(cr_lim) - int'(lo_lim) + 160))));
            vld  = ($urandom_range(0, 1) == 1);
            clr  = ($urandom_range(0, 7) == 0);
            step(crit_only ? "R6" : (int_mode ? "R7" : "R4"));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule